// File: doc/BRIEF.md
# Flash XIP Mode Sequencer

This block keeps track of whether an attached serial flash is executing in place, which means it accepts reads without an opcode. For every read it decides whether the command builder must send the read opcode, whether mode bits follow the address, and which mode byte to place there. Software drives two configuration levels. The first, cfg_xip_now, declares that the device is already in XIP mode, for example after a power-up from a non-volatile setting. The second, cfg_xip_next, arms entry so that the following read carries the full command together with the entering mode byte.

Leaving XIP mode is never immediate. When both enables drop while XIP is active, the block moves to an exit-pending state. The device still expects opcode-less reads, so the next read goes out without an opcode but carries the releasing mode byte. Only after that read completes do later reads carry the opcode again. The transfer engine talks to the block through a single-cycle request pulse and a single-cycle completion pulse. An idle status bit, delayed through a two-flop synchronizer, reports that the block is neither busy with a read nor waiting to exit.

Top module: `xip_sequencer`

## Requirements
- R1: While rst is high, and on the cycle it is released, xip_active, send_opcode, send_mode_bits, mode_byte and idle_status are all 0.
- R2: With both enables low and XIP off, an accepted read gives send_opcode=1, send_mode_bits=0 and mode_byte=0x00, and xip_active stays 0. mode_byte is 0x00 whenever send_mode_bits is 0.
- R3: Setting cfg_xip_now while XIP is off raises xip_active on the next clock edge. The following read gives send_opcode=0, send_mode_bits=1 and mode_byte=0xA0.
- R4: Setting cfg_xip_next while XIP is off leaves xip_active at 0. The following read gives send_opcode=1, send_mode_bits=1 and mode_byte=0xA0, and xip_active rises on the edge that accepts rd_done. If cfg_xip_next is cleared again before any read, the next read behaves as in R2.
- R5: When both enables are set together while XIP is off, the behaviour is that of R3 (immediate entry wins).
- R6: While XIP is active and at least one enable is set, every read gives send_opcode=0, send_mode_bits=1 and mode_byte=0xA0.
- R7: Clearing both enables while XIP is active keeps xip_active at 1. The next read gives send_opcode=0, send_mode_bits=1 and mode_byte=0xFF. On the edge that accepts its rd_done, xip_active falls, and later reads behave as in R2.
- R8: Setting either enable again while exit is pending, before the exit read starts, cancels the exit: the next read behaves as in R6.
- R9: A read is accepted on a clock edge where rd_req=1 and no read is outstanding. The per-read outputs update on that edge and hold until the next accepted read. rd_req while a read is outstanding is ignored, and so is rd_done with no read outstanding. Enable changes made during an outstanding read take effect only after its rd_done.
- R10: idle_status equals the internal idle condition (no outstanding read and no pending exit) delayed by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_xip_now | input | 1 | Device is already in XIP mode (immediate entry) |
| cfg_xip_next | input | 1 | Enter XIP mode with the next read |
| rd_req | input | 1 | Single-cycle pulse that starts a read |
| rd_done | input | 1 | Single-cycle pulse that ends the outstanding read |
| send_opcode | output | 1 | Current read must send the read opcode |
| send_mode_bits | output | 1 | Current read must send mode bits |
| mode_byte | output | 8 | Mode byte for the current read, 0x00 when unused |
| xip_active | output | 1 | Device is treated as being in XIP mode |
| idle_status | output | 1 | Retimed idle indication |

## Verification
A wrong internal state appears as a wrong opcode or mode-byte decision on the very next accepted read, one edge after rd_req. The most common symptom is a read that sends the opcode to a device that is in XIP mode, or an exit read that carries 0xA0. A wrong pending state also shows on xip_active one edge after an enable change or a completion, and on idle_status two edges after that. The bench therefore follows each enable pattern with reads and samples the plan on the edge after acceptance. It also probes xip_active between reads so that exit-pending and arm/disarm states are seen before a read hides them.

// File: rtl/xip_seq_pkg.sv
package xip_seq_pkg;
    localparam int MODE_W = 8;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ARMED  = 2'd1,
        ST_XIP    = 2'd2,
        ST_EXIT   = 2'd3
    } xip_state_e;

    typedef struct packed {
        logic              send_opcode;
        logic              send_mode;
        logic [MODE_W-1:0] mode_byte;
    } read_plan_t;

    // State change caused by the enable levels while no read is outstanding.
    function automatic xip_state_e cfg_step(xip_state_e s, logic now, logic next);
        xip_state_e r;
        case (s)
            ST_NORMAL, ST_ARMED: r = now ? ST_XIP : (next ? ST_ARMED : ST_NORMAL);
            default:             r = (now || next) ? ST_XIP : ST_EXIT;
        endcase
        return r;
    endfunction

    // Command shape of a read issued from a given state.
    function automatic read_plan_t plan_for(xip_state_e s,
                                            logic [MODE_W-1:0] stay,
                                            logic [MODE_W-1:0] leave);
        read_plan_t p;
        case (s)
            ST_NORMAL: p = '{send_opcode: 1'b1, send_mode: 1'b0, mode_byte: '0};
            ST_ARMED:  p = '{send_opcode: 1'b1, send_mode: 1'b1, mode_byte: stay};
            ST_XIP:    p = '{send_opcode: 1'b0, send_mode: 1'b1, mode_byte: stay};
            default:   p = '{send_opcode: 1'b0, send_mode: 1'b1, mode_byte: leave};
        endcase
        return p;
    endfunction

    // State the device is in once a read from the given state has completed.
    function automatic xip_state_e after_read(xip_state_e s);
        return (s == ST_ARMED || s == ST_XIP) ? ST_XIP : ST_NORMAL;
    endfunction
endpackage

// File: rtl/xip_state_ctrl.sv
module xip_state_ctrl
    import xip_seq_pkg::*;
#(
    parameter logic [MODE_W-1:0] MODE_STAY  = 8'hA0,
    parameter logic [MODE_W-1:0] MODE_LEAVE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_now,
    input  logic       cfg_next,
    input  logic       rd_req,
    input  logic       rd_done,
    output read_plan_t plan,
    output xip_state_e state,
    output logic       busy
);
    xip_state_e stepped;
    xip_state_e pend_next;
    logic       accept;

    assign stepped = cfg_step(state, cfg_now, cfg_next);
    assign accept  = rd_req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_NORMAL;
            pend_next <= ST_NORMAL;
            busy      <= 1'b0;
            plan      <= '0;
        end else if (busy) begin
            if (rd_done) begin
                state <= pend_next;
                busy  <= 1'b0;
            end
        end else begin
            state <= stepped;
            if (accept) begin
                plan      <= plan_for(stepped, MODE_STAY, MODE_LEAVE);
                pend_next <= after_read(stepped);
                busy      <= 1'b1;
            end
        end
    end

    // R9: the plan only moves on an accepted request
    assert_plan_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(plan));

    // R9: enable changes are frozen while a read is outstanding
    assert_state_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_done) |=> $stable(state));

    // R7: an outstanding exit read carries the releasing byte and no opcode
    assert_exit_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && state == ST_EXIT) |-> (plan.mode_byte == MODE_LEAVE && !plan.send_opcode));

    // R7: completing the exit read returns to normal reads
    assert_exit_done_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_done && state == ST_EXIT) |=> state == ST_NORMAL);

    // R2: a mode byte is present exactly when mode bits are sent
    assert_mode_flag_R2: assert property (@(posedge clk) disable iff (rst)
        plan.send_mode == (plan.mode_byte != '0));

    // R3: a read with opcode never carries the releasing byte
    assert_opcode_leave_R3: assert property (@(posedge clk) disable iff (rst)
        plan.send_opcode |-> plan.mode_byte != MODE_LEAVE);
endmodule

// File: rtl/xip_idle_sync.sv
module xip_idle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xip_sequencer.sv
module xip_sequencer
    import xip_seq_pkg::*;
#(
    parameter logic [MODE_W-1:0] MODE_STAY  = 8'hA0,
    parameter logic [MODE_W-1:0] MODE_LEAVE = 8'hFF,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_xip_now,
    input  logic              cfg_xip_next,
    input  logic              rd_req,
    input  logic              rd_done,
    output logic              send_opcode,
    output logic              send_mode_bits,
    output logic [MODE_W-1:0] mode_byte,
    output logic              xip_active,
    output logic              idle_status
);
    read_plan_t plan;
    xip_state_e state;
    logic       busy;
    logic       idle_int;
    logic [1:0] settle;

    xip_state_ctrl #(.MODE_STAY(MODE_STAY), .MODE_LEAVE(MODE_LEAVE)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_now  (cfg_xip_now),
        .cfg_next (cfg_xip_next),
        .rd_req   (rd_req),
        .rd_done  (rd_done),
        .plan     (plan),
        .state    (state),
        .busy     (busy)
    );

    assign idle_int = !busy && (state != ST_EXIT);

    xip_idle_sync #(.STAGES(SYNC_STAGES)) u_idle (
        .clk (clk),
        .rst (rst),
        .d   (idle_int),
        .q   (idle_status)
    );

    assign send_opcode    = plan.send_opcode;
    assign send_mode_bits = plan.send_mode;
    assign mode_byte      = plan.mode_byte;
    assign xip_active     = (state == ST_XIP) || (state == ST_EXIT);

    // Cycles since reset release, saturating, used to gate the lag check.
    always_ff @(posedge clk) begin
        if (rst)                settle <= 2'd0;
        else if (settle != 2'd3) settle <= settle + 2'd1;
    end

    // R10: status lags the internal idle condition by two edges
    assert_idle_lag_R10: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3) |-> idle_status == $past(idle_int, 2));

    // R7: a pending exit still counts as XIP and is never idle
    assert_exit_not_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXIT) |-> (xip_active && !idle_int));
endmodule

// File: tb/xip_sequencer_test.sv
module xip_sequencer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_xip_now = 1'b0;
    logic       cfg_xip_next = 1'b0;
    logic       rd_req = 1'b0;
    logic       rd_done = 1'b0;
    logic       send_opcode, send_mode_bits, xip_active, idle_status;
    logic [7:0] mode_byte;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xip_sequencer uut (
        .clk(clk), .rst(rst), .cfg_xip_now(cfg_xip_now), .cfg_xip_next(cfg_xip_next),
        .rd_req(rd_req), .rd_done(rd_done), .send_opcode(send_opcode),
        .send_mode_bits(send_mode_bits), .mode_byte(mode_byte),
        .xip_active(xip_active), .idle_status(idle_status)
    );

    // {now, next, exp_opcode, exp_mode, exp_byte, exp_xip_after_done}
    localparam logic [12:0] VEC [0:11] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},   // R2 plain
        {1'b0, 1'b1, 1'b1, 1'b1, 8'hA0, 1'b1},   // R4 entry read
        {1'b0, 1'b1, 1'b0, 1'b1, 8'hA0, 1'b1},   // R6 stay
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0},   // R7 exit read
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},   // R7 plain after exit
        {1'b1, 1'b0, 1'b0, 1'b1, 8'hA0, 1'b1},   // R3 immediate
        {1'b1, 1'b0, 1'b0, 1'b1, 8'hA0, 1'b1},   // R6 stay
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0},   // R7 exit read
        {1'b1, 1'b1, 1'b0, 1'b1, 8'hA0, 1'b1},   // R5 both set
        {1'b0, 1'b1, 1'b0, 1'b1, 8'hA0, 1'b1},   // R6 stay on next enable
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0},   // R7 exit read
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}    // R2 plain
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_plan(input string req, input logic op, input logic mb, input logic [7:0] b);
        chk({req, " opcode"}, {7'd0, send_opcode}, {7'd0, op});
        chk({req, " mode_bits"}, {7'd0, send_mode_bits}, {7'd0, mb});
        chk({req, " mode_byte"}, mode_byte, b);
    endtask

    // Apply enables, let one edge step them, then issue an accepted request.
    task automatic read_begin(input logic now, input logic next);
        cfg_xip_now  = now;
        cfg_xip_next = next;
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic read_end();
        @(negedge clk);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 xip_active", {7'd0, xip_active}, 8'd0);
        chk_plan("R1", 1'b0, 1'b0, 8'h00);
        chk("R1 idle_status", {7'd0, idle_status}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle_status first edge", {7'd0, idle_status}, 8'd0);
        @(negedge clk);
        chk("R10 idle_status rises", {7'd0, idle_status}, 8'd1);

        for (int i = 0; i < 12; i++) begin
            read_begin(VEC[i][12], VEC[i][11]);
            chk_plan($sformatf("vector %0d", i), VEC[i][10], VEC[i][9], VEC[i][8:1]);
            read_end();
            chk($sformatf("vector %0d xip_active", i), {7'd0, xip_active}, {7'd0, VEC[i][0]});
        end

        // R4 arm then disarm before any read
        cfg_xip_next = 1'b1;
        @(negedge clk);
        chk("R4 armed xip_active", {7'd0, xip_active}, 8'd0);
        cfg_xip_next = 1'b0;
        @(negedge clk);
        read_begin(1'b0, 1'b0);
        chk_plan("R4 disarmed", 1'b1, 1'b0, 8'h00);
        read_end();

        // R7 pending exit keeps XIP, R8 re-enable cancels it
        read_begin(1'b1, 1'b0);
        read_end();
        cfg_xip_now = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 pending xip_active", {7'd0, xip_active}, 8'd1);
        read_begin(1'b1, 1'b0);
        chk_plan("R8 cancelled exit", 1'b0, 1'b1, 8'hA0);
        read_end();

        // R9 request while busy ignored, enables deferred; R10 idle lag
        @(negedge clk);
        @(negedge clk);
        read_begin(1'b1, 1'b0);
        chk("R10 idle after accept edge", {7'd0, idle_status}, 8'd1);
        cfg_xip_now = 1'b0;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R10 idle one edge later", {7'd0, idle_status}, 8'd1);
        chk_plan("R9 busy request ignored", 1'b0, 1'b1, 8'hA0);
        @(negedge clk);
        chk("R10 idle two edges later", {7'd0, idle_status}, 8'd0);
        chk("R9 enable deferred", {7'd0, xip_active}, 8'd1);
        read_end();
        read_begin(1'b0, 1'b0);
        chk_plan("R9 deferred exit", 1'b0, 1'b1, 8'hFF);
        read_end();

        // R9 stray completion with nothing outstanding
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        @(negedge clk);
        chk("R9 stray done xip_active", {7'd0, xip_active}, 8'd0);
        read_begin(1'b0, 1'b0);
        chk_plan("R9 after stray done", 1'b1, 1'b0, 8'h00);
        read_end();

        summary();
        $finish;
    end
endmodule